// File: doc/BRIEF.md
# Two-Step Refresh Watchdog Timer

This block is a software watchdog built around a 16-bit up-counter. A prescaler turns the system clock into counter ticks. A tick comes every 24 clocks or every 384 clocks, and the top bit of an 8-bit reload register chooses which. After reset the watchdog is idle. A start write enables it, and from then on only reset can stop it.

Software keeps the watchdog alive with a two-write sequence. First it writes the arm bit. Then, within 12 clocks, it writes the start bit. A completed sequence loads the counter from the reload register and restarts the prescaler. If the start write comes late, the arm bit lapses and the counter keeps its value. When the counter reaches 0x7CFF, a live timeout flag goes high. A registered reset request then rises and stays high until reset.

Top module: `wdog_2step`

## Requirements
- R1: After reset `timeout_now` and `rst_req` are low, the watchdog is idle, and the counter, reload register, arm state and prescaler are zero.
- R2: Once enabled, the counter advances once every 24 clocks when reload bit 7 is 0, and once every 384 clocks when reload bit 7 is 1.
- R3: A reload puts reload bits 6:0 into counter bits 14:8. Counter bit 15 and bits 7:0 load as zero.
- R4: A start write enables the watchdog. No later write can disable it; only reset does.
- R5: An arm write sampled at edge t, followed by a start write sampled at edge t+k with 1 <= k <= 12, reloads the counter at edge t+k. The arm state then clears.
- R6: If no start write arrives by edge t+12, the arm state clears. A start write at t+13 or later does not reload.
- R7: `timeout_now` is high exactly while the watchdog is enabled and the counter equals 0x7CFF. After a reload at edge E with counter value 0x7C00 and tick period P, it rises after edge E+255P and falls after edge E+256P.
- R8: `rst_req` rises one clock after `timeout_now` and stays high until reset.
- R9: A start write with no pending arm, made while the watchdog runs, leaves the counter and the timeout time unchanged.
- R10: Every reload resets the prescaler, so the first tick after a refresh comes a full period P later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_wr | input | 1 | Write strobe setting the arm bit |
| start_wr | input | 1 | Write strobe setting the start bit |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_din | input | 8 | Reload register data; bit 7 selects the prescale |
| timeout_now | output | 1 | Live timeout status, high while the counter sits at 0x7CFF |
| rst_req | output | 1 | Sticky registered reset request |

## Verification
The counter has no port, so its value can only be read from the exact clock on which the timeout appears. Each run loads 0x7C00 through a refresh, which puts the trip point 255 ticks away. The bench then compares the arrival clock with 255P, which brings the hidden count and the prescaler phase out to the ports. To reach a prescaler phase that is not zero at the moment of a refresh, the bench runs the watchdog for an odd number of clocks before refreshing again. Late starts and stray writes are placed in the middle of a timed run, so any unwanted reload would shift the arrival clock.

// File: rtl/wdog_2step.sv
module wdog_2step #(
  parameter int CNT_W    = 16,
  parameter int RLD_W    = 8,
  parameter int TRIP     = 16'h7CFF,
  parameter int WIN      = 12,
  parameter int FAST_DIV = 24,
  parameter int SLOW_MUL = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_wr,
  input  logic             start_wr,
  input  logic             reload_wr,
  input  logic [RLD_W-1:0] reload_din,
  output logic             timeout_now,
  output logic             rst_req
);

  localparam int SLOW_DIV = FAST_DIV * SLOW_MUL;
  localparam int PRE_W    = $clog2(SLOW_DIV);
  localparam int WIN_W    = $clog2(WIN + 1);
  localparam int SEG_LO   = CNT_W - RLD_W;

  logic             en;
  logic [CNT_W-1:0] cnt;
  logic [RLD_W-1:0] rld;
  logic [PRE_W-1:0] pre;
  logic [WIN_W-1:0] arm_left;

  wire             armed   = arm_left != '0;
  wire             refresh = start_wr && armed;
  wire [PRE_W-1:0] pre_lim = rld[RLD_W-1] ? PRE_W'(SLOW_DIV - 1) : PRE_W'(FAST_DIV - 1);
  wire             tick    = en && (pre >= pre_lim);
  wire [CNT_W-1:0] rld_val = {1'b0, rld[RLD_W-2:0], {SEG_LO{1'b0}}};

  assign timeout_now = en && (cnt == CNT_W'(TRIP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rld <= '0;
    else if (reload_wr) rld <= reload_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else if (start_wr) en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_left <= '0;
    else if (arm_wr) arm_left <= WIN_W'(WIN);
    else if (refresh) arm_left <= '0;
    else if (armed) arm_left <= arm_left - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (refresh) pre <= '0;
    else if (en) pre <= tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (refresh) cnt <= rld_val;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else if (timeout_now) rst_req <= 1'b1;
  end

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) en |=> en);

  // R8
  req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> rst_req);

  // R8
  req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) timeout_now |=> rst_req);

  // R6
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) arm_left <= WIN_W'(WIN));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (cnt == $past(rld_val)) && (pre == '0) && !armed || $past(arm_wr));

  // R7
  trip_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_now && tick && !refresh) |=> !timeout_now);

endmodule

// File: tb/sim_wdog_2step.sv
module sim_wdog_2step;
  localparam int TCLK = 10;
  localparam int FAST = 24;
  localparam int SLOW = 384;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_wr = 1'b0, start_wr = 1'b0, reload_wr = 1'b0;
  logic [7:0] reload_din = '0;
  logic timeout_now, rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  wdog_2step u0 (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .start_wr(start_wr),
    .reload_wr(reload_wr), .reload_din(reload_din),
    .timeout_now(timeout_now), .rst_req(rst_req)
  );

  always #(TCLK/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic refresh(input int k, input logic [7:0] rv);
    reload_wr = 1'b1;
    reload_din = rv;
    @(negedge clk);
    reload_wr = 1'b0;
    arm_wr = 1'b1;
    @(negedge clk);
    arm_wr = 1'b0;
    repeat (k - 1) @(negedge clk);
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  // mode 0: quiet, 1: bare start at 1000, 2: arm at 1000 then start 13 clocks later
  task automatic expect_trip(input int p, input int mode, input string req);
    bit early = 1'b0;
    for (int i = 1; i < 255 * p; i++) begin
      @(negedge clk);
      if (mode == 1 && i == 1000) start_wr = 1'b1;
      if (mode == 1 && i == 1001) start_wr = 1'b0;
      if (mode == 2 && i == 1000) arm_wr = 1'b1;
      if (mode == 2 && i == 1001) arm_wr = 1'b0;
      if (mode == 2 && i == 1013) start_wr = 1'b1;
      if (mode == 2 && i == 1014) start_wr = 1'b0;
      if (timeout_now || rst_req) early = 1'b1;
    end
    chk(!early, {req, " no early timeout"}, early, 0);
    @(negedge clk);
    chk(timeout_now == 1'b1, {req, " R7 rise at 255P"}, timeout_now, 1);
    chk(rst_req == 1'b0, {req, " R8 request lags one clock"}, rst_req, 0);
    @(negedge clk);
    chk(rst_req == 1'b1, {req, " R8 request raised"}, rst_req, 1);
    repeat (p - 1) @(negedge clk);
    chk(timeout_now == 1'b0, {req, " R7 fall at 256P"}, timeout_now, 0);
    chk(rst_req == 1'b1, {req, " R8 request sticky"}, rst_req, 1);
  endtask

  initial begin
    do_reset();
    // R1
    chk(timeout_now == 1'b0, "R1 timeout low after reset", timeout_now, 0);
    chk(rst_req == 1'b0, "R1 request low after reset", rst_req, 0);

    // R5 R3 R2 R9: earliest start, fast prescale, bare start mid-run
    refresh(1, 8'h7C);
    expect_trip(FAST, 1, "R5 k=1 R3 R2 R9");

    // R5 R6: latest start, lapsed arm mid-run must not reload
    do_reset();
    chk(rst_req == 1'b0, "R1 reset clears request", rst_req, 0);
    refresh(12, 8'h7C);
    expect_trip(FAST, 2, "R5 k=12 R6");

    // R6 R4: start at k=13 only enables from zero, no reload
    do_reset();
    refresh(13, 8'h7C);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 255 * FAST + 100; i++) begin
        @(negedge clk);
        if (timeout_now || rst_req) seen = 1'b1;
      end
      chk(!seen, "R6 late start gives no reload", seen, 0);
    end

    // R10 R4: second refresh at an odd prescaler phase
    do_reset();
    refresh(3, 8'h7C);
    repeat (3001) @(negedge clk);
    refresh(12, 8'h7C);
    expect_trip(FAST, 0, "R10 prescaler restart");

    // R2: slow prescale
    do_reset();
    refresh(6, 8'hFC);
    expect_trip(SLOW, 0, "R2 slow prescale");

    do_reset();
    chk(timeout_now == 1'b0 && rst_req == 1'b0, "R1 final reset", rst_req, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule